// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns one internal access request at a time into a cycle on an external bus whose 64 data lines also carry the address and the transfer size. Each cycle opens with a single address cycle. In that cycle the address, a copy of the size code, the start strobe, the chip select and the frame marker are all presented together. Then come one data beat, or a run of beats that fills a whole 32-byte line. The target paces every beat with its ready line. The master holds the bus, and keeps chip select low, until the last beat completes.

The request side is a valid/ready stream. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high while the block is idle and during the clock that completes the final beat of the current access. A requester that keeps `req_valid` high therefore gets its next access started with no idle clock between the two. Responses have no back-pressure: `rsp_valid` pulses once per completed beat and must be taken on that clock. For writes, the source watches `beat_addr` and places the matching data on `wr_data` in the same cycle.

Top module: `mpx_bus_master`

## Requirements
- R1: In the address cycle the block drives the bus (`bus_oe` high). `bus_dout[25:0]` carries the request address, and `bus_dout[63:61]` and `bus_dout[31:29]` both carry the size code. All other bits are zero.
- R2: `bus_bs` is high for exactly one clock per accepted request, and that clock is the address cycle.
- R3: `bus_cs_n` goes low in the address cycle and stays low until the final beat completes. When the next request is waiting at that moment, its address cycle follows at once and chip select never rises.
- R4: `bus_frame` is high in the address cycle and in every non-final beat, including its wait states. It is low from the first clock of the final beat, and it is never high while chip select is high.
- R5: Size codes 000 (byte), 001 (word), 010 (longword) and 011 (quadword) make one data beat. Any code with bit 2 set makes a line burst of LINE_BYTES/8 beats, four by default. `rsp_last` marks the final beat.
- R6: Burst beats address the 8-byte words of the aligned line. They start at the word that holds the request address and step upward, wrapping inside the line, with `beat_addr[2:0]` zero (request 0x10 gives 0x10, 0x18, 0x00, 0x08). A single-beat access shows the request address unchanged on `beat_addr`.
- R7: A beat completes on the clock where `bus_rdy` is high, and `beat_addr` holds while `bus_rdy` is low. For reads, `rsp_data` equals `bus_din` on that clock and `rsp_valid` pulses.
- R8: During the data beats of a write, `bus_oe` is high and `bus_dout` equals `wr_data`. During the data beats of a read, `bus_oe` is low.
- R9: `req_ready` is low in the address cycle and in every data clock except the one that completes the final beat.
- R10: While reset is held, `bus_cs_n` is high, and `bus_bs`, `bus_frame`, `bus_oe` and `rsp_valid` are low, with `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on this clock if valid |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 3 | Size code: 000 byte, 001 word, 010 longword, 011 quadword, 1xx line burst |
| req_write | input | 1 | 1 = write, 0 = read |
| beat_addr | output | ADDR_W | Address of the beat in progress |
| wr_data | input | 64 | Write data for the beat shown on beat_addr |
| rsp_valid | output | 1 | A data beat completed this clock |
| rsp_last | output | 1 | The completed beat is the final one |
| rsp_data | output | 64 | Read data of the completed beat |
| bus_dout | output | 64 | Multiplexed address/data lines, outbound |
| bus_oe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 64 | Multiplexed data lines, inbound |
| bus_bs | output | 1 | Address-cycle strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_frame | output | 1 | High until the final beat starts |
| bus_rdy | input | 1 | Target completes the current beat |

## Verification
The bench builds the block with ADDR_W = 26 and LINE_BYTES = 32. With these values all 26 address lines of the address word are driven, and a burst has four beats, so wrapping can be seen from every start offset in a line, including the top word of a line near the end of the address space. The target model inserts zero, one or two wait clocks per beat in turn. This covers the hold of `beat_addr` and `bus_frame` during waits, and a final beat that completes the very clock it starts. A chain of three requests shows the hand-over without a chip-select gap.

// File: rtl/mpx_pkg.sv
`timescale 1ns/1ps
package mpx_pkg;
  localparam int BUS_W        = 64;
  localparam int ADDR_FIELD_W = 26;
  localparam int SIZE_W       = 3;
  localparam int SIZE_HI_LSB  = 61;
  localparam int SIZE_LO_LSB  = 29;
  localparam int BEAT_OFF_W   = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  function automatic logic size_is_line(input logic [SIZE_W-1:0] s);
    return s[SIZE_W-1];
  endfunction
endpackage

// File: rtl/mpx_addr_word.sv
`timescale 1ns/1ps
module mpx_addr_word
  import mpx_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [BUS_W-1:0]  word
);
  // address occupies the low lines, size code is mirrored in two places
  always_comb begin
    word = '0;
    word[ADDR_W-1:0] = addr;
    word[SIZE_HI_LSB +: SIZE_W] = size;
    word[SIZE_LO_LSB +: SIZE_W] = size;
  end
endmodule

// File: rtl/mpx_beat_seq.sv
`timescale 1ns/1ps
module mpx_beat_seq
  import mpx_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int LINE_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_line,
  input  logic              advance,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              last_beat
);
  localparam int IDX_W      = $clog2(LINE_BEATS);
  localparam int LINE_OFF_W = BEAT_OFF_W + IDX_W;

  logic [ADDR_W-1:0] base_q;
  logic              line_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      line_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      line_q <= load_line;
      cnt_q  <= '0;
    end else if (advance && !last_beat) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // word index inside the line wraps by plain modulo arithmetic
  assign idx       = base_q[LINE_OFF_W-1:BEAT_OFF_W] + cnt_q;
  assign base_addr = base_q;
  assign beat_addr = line_q ? {base_q[ADDR_W-1:LINE_OFF_W], idx, {BEAT_OFF_W{1'b0}}} : base_q;
  assign last_beat = !line_q || (cnt_q == IDX_W'(LINE_BEATS - 1));

  p_wrap_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last_beat && !load) |=>
      (beat_addr[LINE_OFF_W-1:BEAT_OFF_W] == IDX_W'($past(beat_addr[LINE_OFF_W-1:BEAT_OFF_W]) + 1'b1)));

  p_same_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last_beat && !load) |=>
      (beat_addr[ADDR_W-1:LINE_OFF_W] == $past(beat_addr[ADDR_W-1:LINE_OFF_W])));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(beat_addr));
endmodule

// File: rtl/mpx_bus_ctl.sv
`timescale 1ns/1ps
module mpx_bus_ctl
  import mpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   bus_rdy,
  input  logic   last_beat,
  output logic   req_ready,
  output logic   load,
  output logic   advance,
  output phase_e phase
);
  phase_e ph_q, ph_d;

  always_comb begin
    req_ready = (ph_q == PH_IDLE) || ((ph_q == PH_DATA) && bus_rdy && last_beat);
    load      = req_valid && req_ready;
    advance   = (ph_q == PH_DATA) && bus_rdy;
    ph_d      = ph_q;
    case (ph_q)
      PH_IDLE: if (load) ph_d = PH_ADDR;
      PH_ADDR: ph_d = PH_DATA;
      PH_DATA: if (advance && last_beat) ph_d = load ? PH_ADDR : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

  p_addr_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR) |=> (ph_q == PH_DATA));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR) |-> !req_ready);

  p_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last_beat && req_valid) |=> (ph_q == PH_ADDR));

  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_DATA) && !bus_rdy) |=> (ph_q == PH_DATA));
endmodule

// File: rtl/mpx_bus_master.sv
`timescale 1ns/1ps
module mpx_bus_master
  import mpx_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_write,
  output logic [ADDR_W-1:0] beat_addr,
  input  logic [63:0]       wr_data,
  output logic              rsp_valid,
  output logic              rsp_last,
  output logic [63:0]       rsp_data,
  output logic [63:0]       bus_dout,
  output logic              bus_oe,
  input  logic [63:0]       bus_din,
  output logic              bus_bs,
  output logic              bus_cs_n,
  output logic              bus_frame,
  input  logic              bus_rdy
);
  localparam int LINE_BEATS = LINE_BYTES / (BUS_W / 8);

  phase_e            phase;
  logic              load, advance, last_beat;
  logic [ADDR_W-1:0] base_addr;
  logic [BUS_W-1:0]  addr_word;
  logic [SIZE_W-1:0] size_q;
  logic              write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= '0;
      write_q <= 1'b0;
    end else if (load) begin
      size_q  <= req_size;
      write_q <= req_write;
    end
  end

  mpx_bus_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bus_rdy   (bus_rdy),
    .last_beat (last_beat),
    .req_ready (req_ready),
    .load      (load),
    .advance   (advance),
    .phase     (phase)
  );

  mpx_beat_seq #(.ADDR_W(ADDR_W), .LINE_BEATS(LINE_BEATS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (req_addr),
    .load_line (size_is_line(req_size)),
    .advance   (advance),
    .base_addr (base_addr),
    .beat_addr (beat_addr),
    .last_beat (last_beat)
  );

  mpx_addr_word #(.ADDR_W(ADDR_W)) u_aw (
    .addr (base_addr),
    .size (size_q),
    .word (addr_word)
  );

  always_comb begin
    bus_bs    = (phase == PH_ADDR);
    bus_cs_n  = (phase == PH_IDLE);
    bus_frame = (phase == PH_ADDR) || ((phase == PH_DATA) && !last_beat);
    bus_oe    = (phase == PH_ADDR) || ((phase == PH_DATA) && write_q);
    if (phase == PH_ADDR)                   bus_dout = addr_word;
    else if ((phase == PH_DATA) && write_q) bus_dout = wr_data;
    else                                    bus_dout = '0;
    rsp_valid = advance;
    rsp_last  = advance && last_beat;
    rsp_data  = (advance && !write_q) ? bus_din : '0;
  end

  p_bs_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bs |=> !bus_bs);

  p_frame_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_frame |-> !bus_cs_n);

  p_frame_low_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> !bus_frame);

  p_cs_through_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> !bus_cs_n);

  p_read_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_bs && !write_q) |-> !bus_oe);

  p_size_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_bs |-> (bus_dout[63:61] == bus_dout[31:29]));
endmodule

// File: tb/test_mpx_bus_master.sv
`timescale 1ns/1ps
module test_mpx_bus_master;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic [AW-1:0] beat_addr;
  logic [63:0]   wr_data;
  logic          rsp_valid, rsp_last;
  logic [63:0]   rsp_data, bus_dout, bus_din;
  logic          bus_oe, bus_bs, bus_cs_n, bus_frame;
  logic          bus_rdy = 1'b0;

  always #2.5 clk = ~clk;

  mpx_bus_master #(.ADDR_W(AW), .LINE_BYTES(32)) i_mpx_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .beat_addr(beat_addr), .wr_data(wr_data), .rsp_valid(rsp_valid),
    .rsp_last(rsp_last), .rsp_data(rsp_data), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din(bus_din), .bus_bs(bus_bs), .bus_cs_n(bus_cs_n),
    .bus_frame(bus_frame), .bus_rdy(bus_rdy)
  );

  function automatic logic [63:0] rpat(input logic [AW-1:0] a);
    return {32'h5A00_0000 ^ {6'b0, a}, ~{6'b0, a}};
  endfunction
  function automatic logic [63:0] wpat(input logic [AW-1:0] a);
    return {~{6'b0, a}, 32'h3C00_0000 ^ {6'b0, a}};
  endfunction

  assign bus_din = rpat(beat_addr);
  assign wr_data = wpat(beat_addr);

  typedef struct {
    logic [AW-1:0] addr;
    logic [63:0]   data;
    logic          last;
    logic          wr;
  } beat_t;

  beat_t       exp_q[$];
  logic [63:0] aw_q[$];
  int n_chk = 0, n_fail = 0, n_req = 0, bs_cnt = 0, gap_cnt = 0;
  logic prev_bs = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes expected address word and beats, then offers the request
  task automatic issue(input logic [AW-1:0] a, input logic [2:0] sz, input logic wr);
    int nb;
    logic [63:0] w;
    nb = sz[2] ? 4 : 1;
    w = '0;
    w[25:0] = a;
    w[63:61] = sz;
    w[31:29] = sz;
    aw_q.push_back(w);
    for (int k = 0; k < nb; k++) begin
      beat_t b;
      logic [1:0] ix;
      ix = a[4:3] + 2'(k);
      b.addr = sz[2] ? {a[AW-1:5], ix, 3'b000} : a;
      b.data = wr ? wpat(b.addr) : rpat(b.addr);
      b.last = (k == nb - 1);
      b.wr   = wr;
      exp_q.push_back(b);
    end
    n_req++;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0);
    repeat (2) @(posedge clk);
  endtask

  // target model: 0,1,2 wait clocks per beat in rotation
  initial begin
    int wait_cnt, pat;
    wait_cnt = 0; pat = 0;
    forever begin
      @(posedge clk); #1;
      if (!rst_n || bus_cs_n) bus_rdy = 1'b0;
      else if (bus_bs) begin
        wait_cnt = pat % 3; pat++; bus_rdy = 1'b0;
      end else begin
        if (bus_rdy) begin wait_cnt = pat % 3; pat++; end
        if (wait_cnt == 0) bus_rdy = 1'b1;
        else begin bus_rdy = 1'b0; wait_cnt--; end
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_cs_n && exp_q.size() != 0) gap_cnt++;
      if (bus_bs) begin
        bs_cnt++;
        chk(!prev_bs, "R2 bs longer than one clock", 64'(prev_bs), 64'd0);
        if (aw_q.size() == 0) chk(1'b0, "R2 unexpected address cycle", 64'd1, 64'd0);
        else begin
          logic [63:0] w;
          w = aw_q.pop_front();
          chk(bus_dout == w, "R1 address word", bus_dout, w);
          chk(bus_oe, "R1 bus driven in address cycle", 64'(bus_oe), 64'd1);
        end
        chk(!bus_cs_n && bus_frame, "R3/R4 cs and frame in address cycle",
            {62'd0, bus_cs_n, bus_frame}, 64'd1);
        chk(!req_ready, "R9 ready low in address cycle", 64'(req_ready), 64'd0);
      end else if (!bus_cs_n) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 data clock with nothing expected", 64'd1, 64'd0);
        else begin
          beat_t h;
          h = exp_q[0];
          chk(bus_frame == !h.last, "R4 frame during beat", 64'(bus_frame), 64'(!h.last));
          chk(req_ready == (rsp_valid && h.last), "R9 ready in data clock",
              64'(req_ready), 64'(rsp_valid && h.last));
          if (rsp_valid) begin
            void'(exp_q.pop_front());
            chk(beat_addr == h.addr, "R6 beat address", 64'(beat_addr), 64'(h.addr));
            chk(rsp_last == h.last, "R5 last marker", 64'(rsp_last), 64'(h.last));
            if (h.wr) begin
              chk(bus_oe, "R8 write drives bus", 64'(bus_oe), 64'd1);
              chk(bus_dout == h.data, "R8 write data", bus_dout, h.data);
            end else begin
              chk(!bus_oe, "R8 read releases bus", 64'(bus_oe), 64'd0);
              chk(rsp_data == h.data, "R7 read data", rsp_data, h.data);
            end
          end
        end
      end else if (rsp_valid) begin
        chk(1'b0, "R7 response while deselected", 64'd1, 64'd0);
      end
      prev_bs = bus_bs;
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(bus_cs_n && !bus_bs && !bus_frame && !bus_oe && !rsp_valid && req_ready,
            "R10 reset state",
            {58'd0, bus_cs_n, bus_bs, bus_frame, bus_oe, rsp_valid, req_ready}, 64'h21);
        @(posedge clk); #1; rst_n = 1'b1;
        issue(26'h0000123, 3'b000, 1'b0);  drain();   // R5 byte read
        issue(26'h0000456, 3'b001, 1'b1);  drain();   // R8 word write
        issue(26'h0ABCDE8, 3'b010, 1'b0);  drain();   // longword read
        issue(26'h1000008, 3'b011, 1'b1);  drain();   // quadword write
        issue(26'h0000010, 3'b100, 1'b0);  drain();   // R6 wrap 10,18,00,08
        issue(26'h00003FD, 3'b100, 1'b1);  drain();   // R6 start at top word
        issue(26'h1234568, 3'b110, 1'b0);  drain();   // R5 1xx is a burst
        issue(26'h3FFFFFF, 3'b111, 1'b0);  drain();   // top of address space
        issue(26'h3FFFFFF, 3'b000, 1'b1);  drain();   // R1 all address lines
        begin
          int g0;
          issue(26'h0000200, 3'b100, 1'b0);           // R3 back to back chain
          g0 = gap_cnt;
          issue(26'h0000308, 3'b011, 1'b1);
          issue(26'h0000418, 3'b101, 1'b1);
          drain();
          chk(gap_cnt == g0, "R3 chip select gap in chain", 64'(gap_cnt - g0), 64'd0);
        end
      end
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", n_chk);
      end
    join_any
    disable fork;
    chk(exp_q.size() == 0, "R5 all beats returned", 64'(exp_q.size()), 64'd0);
    chk(bs_cnt == n_req, "R2 one strobe per request", 64'(bs_cnt), 64'(n_req));
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule